// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block sends a left and a right PCM sample over one serial data line. It is the clock master of the link. A bit clock is divided down from the system clock, and a word clock marks each frame: the word clock is high while the left channel occupies the first half of the frame and low while the right channel occupies the second half. Every data and word-clock change happens while the bit clock falls, so a receiver that samples on the rising bit-clock edge sees stable values.

Three frame layouts are available. Left-justified places each word at the start of its half-frame. Right-justified places it at the end. Slot mode uses the left-justified layout and lets software switch each channel off. In a switched-off slot the line is either driven low or released to high impedance. A one-cycle filter-sync pulse marks the start of the first enabled channel. The clocks run only while the converter is powered up, unless a keep-running input holds them on for shared buses. Samples are captured into holding registers at each frame start, so the inputs may change at any time.

Top module: `asx_tx`

## Requirements
- R1: The bit clock has a period of 2*(div_i+1) system cycles. A frame lasts frame_len_i bit clocks. The word clock is high for bit positions 0 to frame_len_i/2-1 (the left half) and low for the rest. dout_o and wclk_o never change on a cycle in which bclk_o rises.
- R2: In format code 0 (left-justified), each channel sends its word MSB first, with the MSB sampled on the first bit-clock rise of its half-frame. The bits after the word are 0. Word-length codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bits, and only the low bits of each sample input are sent.
- R3: In format code 1 (right-justified), each channel's LSB is sampled on the last bit-clock rise of its half-frame, the word being MSB first and preceded by zeros.
- R4: cfg_err_o is high when the format code is 1 and frame_len_i is at most twice the word length, or when the format code is 3. Otherwise it is low.
- R5: In format code 2 (slot mode, left-justified layout), ch_en_i[0] enables the left slot and ch_en_i[1] enables the right slot. A disabled slot has dout_oe_o low when hiz_i is 1, and dout_o low with dout_oe_o high when hiz_i is 0. In formats 0 and 1 the enables and hiz_i have no effect and the line is always driven.
- R6: In slot mode with both channels disabled, dout_oe_o is low for the whole frame.
- R7: fsync_o is a one-cycle pulse once per frame. It is seen before bit position H = frame_len_i/2 when slot mode has only the right channel enabled, and before position 0 in every other case, including both channels disabled.
- R8: With pwr_up_i and keep_clk_i both low, bclk_o, wclk_o and dout_oe_o are held low. With keep_clk_i high, the clocks run while pwr_up_i is low.
- R9: Both samples are captured at the start of each frame. A change of a sample input during a frame first appears in the next frame.
- R10: While rst_n is low, bclk_o, wclk_o, dout_oe_o and fsync_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up_i | input | 1 | Converter powered up |
| keep_clk_i | input | 1 | Keep clocks running while powered down |
| fmt_i | input | 2 | Format: 0 left-justified, 1 right-justified, 2 slot |
| wlen_i | input | 2 | Word length code: 16, 20, 24, 32 bits |
| frame_len_i | input | FRM_W | Bit clocks per frame (even) |
| div_i | input | DIV_W | Bit-clock half period minus one, in system cycles |
| ch_en_i | input | 2 | Slot enables, bit 0 left, bit 1 right |
| hiz_i | input | 1 | Disabled slot releases the line |
| left_i | input | 32 | Left sample, right-aligned |
| right_i | input | 32 | Right sample, right-aligned |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, high during the left half |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Data output enable |
| fsync_o | output | 1 | Filter-sync pulse |
| cfg_err_o | output | 1 | Invalid configuration flag |

## Verification
The bench samples the outputs like a receiver would. On each falling system-clock edge it looks for a rising bit clock and records dout_o, wclk_o, dout_oe_o and the time at that point. The first rise after power-up is bit position 0. Every expected data bit is therefore compared at the bit-clock rise where a receiver samples it, however many system cycles the divider inserts. A filter-sync pulse is credited to the next bit-clock rise, and cfg_err_o is combinational and is read one time step after each configuration change.

// File: rtl/asx_pkg.sv
package asx_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'd0,
    FMT_RJ   = 2'd1,
    FMT_SLOT = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  function automatic logic [5:0] wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    wl_bits = 6'd16;
      2'd1:    wl_bits = 6'd20;
      2'd2:    wl_bits = 6'd24;
      default: wl_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/asx_clkgen.sv
module asx_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             prime,
  output logic             fall_ev
);
  logic             act_q, act_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic             tick;

  assign prime   = run & ~act_q;
  assign tick    = act_q & (cnt_q == div);
  assign fall_ev = prime | (tick & bclk_q);
  assign bclk    = bclk_q;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!run) begin
      act_d  = 1'b0;
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (prime) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end
endmodule

// File: rtl/asx_framer.sv
module asx_framer #(
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             prime,
  input  logic             fall_ev,
  input  logic [FRM_W-1:0] frame_len,
  input  logic [FRM_W-1:0] half,
  input  logic [FRM_W-1:0] sync_pos,
  output logic [FRM_W-1:0] pos_next,
  output logic             frame_start,
  output logic             wclk,
  output logic             fsync
);
  logic [FRM_W-1:0] pos_q, pos_d;
  logic             wclk_q, wclk_d;
  logic             fsync_q, fsync_d;
  logic [FRM_W-1:0] last_pos;

  assign last_pos    = frame_len - 1'b1;
  assign pos_next    = (prime || pos_q >= last_pos) ? '0 : pos_q + 1'b1;
  assign frame_start = fall_ev && (pos_next == '0);
  assign wclk        = wclk_q;
  assign fsync       = fsync_q;

  always_comb begin
    pos_d   = pos_q;
    wclk_d  = wclk_q;
    fsync_d = fall_ev && (pos_next == sync_pos);
    if (!run) begin
      pos_d   = '0;
      wclk_d  = 1'b0;
      fsync_d = 1'b0;
    end else if (fall_ev) begin
      pos_d  = pos_next;
      wclk_d = pos_next < half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      wclk_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      wclk_q  <= wclk_d;
      fsync_q <= fsync_d;
    end
  end
endmodule

// File: rtl/asx_bitsel.sv
module asx_bitsel import asx_pkg::*; #(
  parameter int FRM_W = 8
) (
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic [FRM_W-1:0]    half,
  input  logic [1:0]          ch_en,
  input  logic                hiz,
  input  logic [FRM_W-1:0]    pos,
  input  logic [SAMPLE_W-1:0] word_l,
  input  logic [SAMPLE_W-1:0] word_r,
  output logic                bit_o,
  output logic                oe_o
);
  localparam int PW = FRM_W + 1;

  logic          ch;
  logic [PW-1:0] k, w, h, idx;
  logic          valid, en, none;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    h     = {1'b0, half};
    w     = PW'(wl_bits(wlen));
    ch    = pos >= half;
    k     = ch ? ({1'b0, pos} - h) : {1'b0, pos};
    word  = ch ? word_r : word_l;
    if (fmt == FMT_RJ) begin
      valid = (k < h) && ((k + w) >= h);
      idx   = h - 1'b1 - k;
    end else begin
      valid = k < w;
      idx   = w - 1'b1 - k;
    end
    en    = (fmt == FMT_SLOT) ? ch_en[ch] : 1'b1;
    none  = (fmt == FMT_SLOT) && (ch_en == 2'b00);
    bit_o = en && valid && word[idx[4:0]];
    oe_o  = !none && (en || !hiz);
  end
endmodule

// File: rtl/asx_tx.sv
module asx_tx import asx_pkg::*; #(
  parameter int DIV_W = 4,
  parameter int FRM_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_up_i,
  input  logic                keep_clk_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic [FRM_W-1:0]    frame_len_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [1:0]          ch_en_i,
  input  logic                hiz_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                dout_o,
  output logic                dout_oe_o,
  output logic                fsync_o,
  output logic                cfg_err_o
);
  logic                run, prime, fall_ev, frame_start;
  logic [FRM_W-1:0]    half, sync_pos, pos_next;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, hold_l_d, hold_r_d;
  logic [SAMPLE_W-1:0] src_l, src_r;
  logic                bit_c, oe_c;
  logic                dout_q, dout_d, oe_q, oe_d;
  logic [FRM_W:0]      twice_w;

  assign run      = pwr_up_i | keep_clk_i;
  assign half     = frame_len_i >> 1;
  assign sync_pos = (fmt_i == FMT_SLOT && !ch_en_i[0] && ch_en_i[1]) ? half : '0;
  assign twice_w  = (FRM_W + 1)'({wl_bits(wlen_i), 1'b0});
  assign cfg_err_o = (fmt_i == FMT_RSV) ||
                     ((fmt_i == FMT_RJ) && ({1'b0, frame_len_i} <= twice_w));

  asx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_i),
    .bclk(bclk_o), .prime(prime), .fall_ev(fall_ev)
  );

  asx_framer #(.FRM_W(FRM_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .prime(prime), .fall_ev(fall_ev),
    .frame_len(frame_len_i), .half(half), .sync_pos(sync_pos),
    .pos_next(pos_next), .frame_start(frame_start),
    .wclk(wclk_o), .fsync(fsync_o)
  );

  assign src_l = frame_start ? left_i  : hold_l_q;
  assign src_r = frame_start ? right_i : hold_r_q;

  asx_bitsel #(.FRM_W(FRM_W)) u_sel (
    .fmt(fmt_i), .wlen(wlen_i), .half(half), .ch_en(ch_en_i), .hiz(hiz_i),
    .pos(pos_next), .word_l(src_l), .word_r(src_r),
    .bit_o(bit_c), .oe_o(oe_c)
  );

  always_comb begin
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    dout_d   = dout_q;
    oe_d     = oe_q;
    if (!run) begin
      dout_d = 1'b0;
      oe_d   = 1'b0;
    end else if (fall_ev) begin
      hold_l_d = src_l;
      hold_r_d = src_r;
      dout_d   = bit_c;
      oe_d     = oe_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      dout_q   <= dout_d;
      oe_q     <= oe_d;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = oe_q;
endmodule

// File: rtl/asx_tx_chk.sv
module asx_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_up_i,
  input logic keep_clk_i,
  input logic bclk_o,
  input logic wclk_o,
  input logic dout_o,
  input logic dout_oe_o,
  input logic fsync_o
);
  p_stable_at_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> ($stable(dout_o) && $stable(wclk_o)));

  p_wclk_moves_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wclk_o) |-> !bclk_o);

  p_fsync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |=> !fsync_o);

  p_fsync_bclk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> !bclk_o);

  p_gated_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_up_i || keep_clk_i) |=> (!bclk_o && !wclk_o && !dout_oe_o));
endmodule

bind asx_tx asx_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up_i), .keep_clk_i(keep_clk_i),
  .bclk_o(bclk_o), .wclk_o(wclk_o), .dout_o(dout_o),
  .dout_oe_o(dout_oe_o), .fsync_o(fsync_o)
);

// File: tb/tb_asx_tx.sv
`timescale 1ns/1ps
module tb_asx_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_up = 1'b0, keep_clk = 1'b0;
  logic [1:0]  fmt = 2'd0, wlen = 2'd0, ch_en = 2'b11;
  logic [7:0]  frame_len = 8'd40;
  logic [3:0]  div = 4'd0;
  logic        hiz = 1'b0;
  logic [31:0] left = '0, right = '0;
  logic        bclk, wclk, dout, oe, fsync, cfg_err;

  always #2 clk = ~clk;

  asx_tx dut (
    .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up), .keep_clk_i(keep_clk),
    .fmt_i(fmt), .wlen_i(wlen), .frame_len_i(frame_len), .div_i(div),
    .ch_en_i(ch_en), .hiz_i(hiz), .left_i(left), .right_i(right),
    .bclk_o(bclk), .wclk_o(wclk), .dout_o(dout), .dout_oe_o(oe),
    .fsync_o(fsync), .cfg_err_o(cfg_err)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  // receiver-side monitor
  logic cap_en = 1'b0;
  int   cap_n = 0, rise_cnt = 0, fs_pos = -1, fs_cnt = 0;
  logic fs_pend = 1'b0, bclk_prev = 1'b0;
  logic cap_d [0:159];
  logic cap_w [0:159];
  logic cap_oe[0:159];
  int   cap_t [0:159];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (fsync) fs_pend = 1'b1;
    if (bclk && !bclk_prev) begin
      rise_cnt++;
      if (cap_en && cap_n < 160) begin
        cap_d[cap_n]  = dout;
        cap_w[cap_n]  = wclk;
        cap_oe[cap_n] = oe;
        cap_t[cap_n]  = cyc;
        if (fs_pend) begin
          if (fs_pos < 0) fs_pos = cap_n;
          fs_cnt++;
        end
        cap_n++;
      end
      fs_pend = 1'b0;
    end
    bclk_prev = bclk;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic restart_capture(input int n);
    @(posedge clk); #1;
    pwr_up = 1'b0; keep_clk = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    cap_n = 0; fs_pos = -1; fs_cnt = 0; fs_pend = 1'b0;
    cap_en = 1'b1;
    pwr_up = 1'b1;
    for (int i = 0; i < 20000 && cap_n < n; i++) @(posedge clk);
    cap_en = 1'b0;
  endtask

  // vector: fmt[82:81] wl[80:79] fl[78:71] div[70:67] en[66:65] hiz[64] l[63:32] r[31:0]
  localparam int NV = 9;
  localparam logic [82:0] VEC [0:NV-1] = '{
    {2'd0, 2'd0, 8'd40, 4'd1, 2'b00, 1'b1, 32'hFFFF_A5C3, 32'h0000_1234},
    {2'd1, 2'd0, 8'd40, 4'd0, 2'b11, 1'b0, 32'h0000_BEEF, 32'hABCD_7001},
    {2'd0, 2'd2, 8'd64, 4'd2, 2'b11, 1'b0, 32'h00AB_CDEF, 32'h0012_3456},
    {2'd2, 2'd0, 8'd40, 4'd0, 2'b10, 1'b1, 32'h0000_FFFF, 32'h0000_8001},
    {2'd2, 2'd1, 8'd48, 4'd1, 2'b01, 1'b0, 32'h000F_0F0F, 32'h000A_AAAA},
    {2'd2, 2'd0, 8'd36, 4'd0, 2'b00, 1'b0, 32'h0000_1234, 32'h0000_5678},
    {2'd1, 2'd3, 8'd66, 4'd0, 2'b11, 1'b0, 32'h8000_0001, 32'h7FFF_FFFE},
    {2'd0, 2'd1, 8'd40, 4'd0, 2'b11, 1'b0, 32'h000C_3A5F, 32'h0009_1111},
    {2'd2, 2'd3, 8'd64, 4'd0, 2'b11, 1'b1, 32'hDEAD_BEEF, 32'h0F0F_1234}
  };

  function automatic int wl_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  task automatic exp_at(input logic [82:0] v, input int p,
                        output logic d, output logic e, output logic w);
    int f, wl, h, k, idx;
    logic ch, en, none, valid;
    logic [31:0] word;
    f  = int'(v[82:81]);
    wl = wl_of(v[80:79]);
    h  = int'(v[78:71]) / 2;
    ch = (p >= h);
    k  = ch ? p - h : p;
    word = ch ? v[31:0] : v[63:32];
    en   = (f == 2) ? v[65 + int'(ch)] : 1'b1;
    none = (f == 2) && (v[66:65] == 2'b00);
    if (f == 1) begin valid = (k >= h - wl); idx = h - 1 - k; end
    else        begin valid = (k < wl);      idx = wl - 1 - k; end
    d = (en && valid) ? word[idx] : 1'b0;
    e = !none && (en || !v[64]);
    w = !ch;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10 bclk in reset", {63'd0, bclk}, 64'd0);
    chk("R10 wclk/oe/fsync in reset", {61'd0, wclk, oe, fsync}, 64'd0);
    rst_n = 1'b1;

    // vector table
    for (int vi = 0; vi < NV; vi++) begin
      logic [82:0] v;
      int fl, mism_d, mism_w, exp_fs;
      string tag;
      logic ed, ee, ew;
      v = VEC[vi];
      fmt = v[82:81]; wlen = v[80:79]; frame_len = v[78:71]; div = v[70:67];
      ch_en = v[66:65]; hiz = v[64]; left = v[63:32]; right = v[31:0];
      fl = int'(v[78:71]);
      restart_capture(fl);
      if (v[82:81] == 2'd0)      tag = "R2";
      else if (v[82:81] == 2'd1) tag = "R3";
      else if (v[66:65] == 2'b00) tag = "R6";
      else                        tag = "R5";
      mism_d = 0; mism_w = 0;
      for (int p = 0; p < fl; p++) begin
        exp_at(v, p, ed, ee, ew);
        if (cap_oe[p] !== ee || (ee && cap_d[p] !== ed)) begin
          if (mism_d == 0)
            $display("  vector %0d %s pos %0d: d=%b oe=%b expected d=%b oe=%b",
                     vi, tag, p, cap_d[p], cap_oe[p], ed, ee);
          mism_d++;
        end
        if (cap_w[p] !== ew) mism_w++;
      end
      chk({tag, " data/enable mismatches"}, 64'(mism_d), 64'd0);
      chk("R1 word clock mismatches", 64'(mism_w), 64'd0);
      chk("R1 bit clock period", 64'(cap_t[2] - cap_t[1]), 64'(2 * (int'(v[70:67]) + 1)));
      exp_fs = (v[82:81] == 2'd2 && v[66:65] == 2'b10) ? fl / 2 : 0;
      chk("R7 fsync position", 64'(fs_pos), 64'(exp_fs));
      chk("R7 fsync count per frame", 64'(fs_cnt), 64'd1);
    end

    // R4: configuration error flag
    @(posedge clk); #1;
    fmt = 2'd1; wlen = 2'd0; frame_len = 8'd32; #1;
    chk("R4 RJ 16b in 32 clocks", {63'd0, cfg_err}, 64'd1);
    frame_len = 8'd34; #1;
    chk("R4 RJ 16b in 34 clocks", {63'd0, cfg_err}, 64'd0);
    fmt = 2'd0; frame_len = 8'd16; #1;
    chk("R4 LJ short frame", {63'd0, cfg_err}, 64'd0);
    fmt = 2'd3; frame_len = 8'd64; #1;
    chk("R4 reserved format", {63'd0, cfg_err}, 64'd1);

    // R9: mid-frame sample change takes effect next frame
    begin
      logic [15:0] f0, f1;
      fmt = 2'd0; wlen = 2'd0; frame_len = 8'd40; div = 4'd0; ch_en = 2'b11; hiz = 1'b0;
      left = 32'h0000_1111; right = 32'h0000_0000;
      @(posedge clk); #1;
      pwr_up = 1'b0; keep_clk = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      cap_n = 0; fs_pos = -1; fs_cnt = 0; cap_en = 1'b1; pwr_up = 1'b1;
      for (int i = 0; i < 20000 && cap_n < 5; i++) @(posedge clk);
      #1 left = 32'h0000_2222;
      for (int i = 0; i < 20000 && cap_n < 80; i++) @(posedge clk);
      cap_en = 1'b0;
      for (int b = 0; b < 16; b++) begin
        f0[15-b] = cap_d[b];
        f1[15-b] = cap_d[40+b];
      end
      chk("R9 current frame keeps old sample", 64'(f0), 64'h1111);
      chk("R9 next frame uses new sample", 64'(f1), 64'h2222);
    end

    // R8: clock gating
    begin
      int r0;
      @(posedge clk); #1;
      pwr_up = 1'b0; keep_clk = 1'b0;
      repeat (3) @(posedge clk);
      r0 = rise_cnt;
      repeat (200) @(posedge clk);
      #1;
      chk("R8 no bit clock while powered down", 64'(rise_cnt - r0), 64'd0);
      chk("R8 outputs idle while powered down", {62'd0, wclk, oe}, 64'd0);
      keep_clk = 1'b1;
      r0 = rise_cnt;
      repeat (200) @(posedge clk);
      #1;
      chk("R8 keep-running clocks active", 64'(rise_cnt - r0 > 0), 64'd1);
      keep_clk = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule